// File: doc/BRIEF.md
# Vector Multiply-Add-Carry Engine

This block is the arithmetic core of a big-integer multiply-accumulate. It steps through a vector of limbs, one element per accepted beat. Each beat forms the 128-bit unsigned value `A * B + C' + K`. `A` and `C` arrive on the input stream. `B` is a scalar word captured at start and reused for every element. `K` is the running carry register. `C'` is either `C` (add form) or the bitwise inverse of `C` (subtract form). The low half of the value leaves on the result stream. The high half replaces the carry register, so the next element picks it up.

Before a sequence, software loads the carry register. A plain multiply-accumulate uses 0. A subtraction uses 1, which turns the inverted addend into a true two's-complement subtraction. A start strobe with a vector length launches the sequence. A one-cycle `done` pulse follows the handshake of the last result. The final carry stays readable on `carry_q` until it is reloaded or changed by a new run.

Both data streams are valid/ready. An input beat is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only during a run, and only while the single result register is empty or is being drained in the same cycle. So a stalled result stream holds off the input stream within the same cycle. A result beat is held unchanged until `out_ready` is seen high.

Top module: `madc_engine`

## Requirements
- R1: In add form (`sub_mode` = 0), each element produces `out_res` equal to bits 63..0 of `in_a * B + in_c + K`, computed as an unsigned 128-bit sum.
- R2: In subtract form (`sub_mode` = 1), `~in_c` is used in place of `in_c`. With K loaded to 1, the limbs A = {5, 0}, C = {7, 0} and B = 3 give the results {8, 0} and a final carry of 1.
- R3: Bits 127..64 of each element's sum replace the carry register and feed the next element. B is the `scalar_b` value sampled on the start cycle, and later changes to `scalar_b` have no effect on a run.
- R4: A `carry_ld` pulse while the engine is idle (`busy` low) writes `carry_ld_val` into the carry register on that edge. A `carry_ld` pulse while `busy` is high is ignored.
- R5: A result appears on the result stream one clock after its element is accepted. `out_idx` carries the element index, and elements are emitted in ascending order starting at 0.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_res` and `out_idx` hold their values.
- R7: A run accepts exactly `vec_len` elements. Input beats offered while no run is active are ignored and produce no result.
- R8: `done` is high for one cycle, one clock after the handshake of the last result. `busy` stays high from the start edge until that handshake.
- R9: A start with `vec_len` = 0 produces no results, leaves the carry register unchanged, and raises `done` one clock later.
- R10: A start strobe while `busy` is high is ignored: the run in progress keeps its length, scalar and form.
- R11: All-ones operands (A, B, C and K each equal to 2^64−1) in add form give an all-ones result and an all-ones carry; the sum never exceeds 128 bits.
- R12: After reset, `out_valid`, `in_ready`, `busy` and `done` are low and the carry register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken only while idle |
| vec_len | input | 8 | Number of elements in the run |
| sub_mode | input | 1 | 0 = add form, 1 = subtract form |
| scalar_b | input | 64 | Scalar multiplier, captured at start |
| carry_ld | input | 1 | Carry register load strobe, taken only while idle |
| carry_ld_val | input | 64 | Value written by `carry_ld` |
| carry_q | output | 64 | Current carry register |
| busy | output | 1 | Run active or last result not yet drained |
| done | output | 1 | One-cycle end-of-run pulse |
| in_valid | input | 1 | Input element beat valid |
| in_ready | output | 1 | Engine can take an element this cycle |
| in_a | input | 64 | Per-element multiplicand limb |
| in_c | input | 64 | Per-element addend limb |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 64 | Low half of the element sum |
| out_idx | output | 8 | Index of the element in `out_res` |

## Verification
The result and the new carry value come from the same register edge that accepts an element, so both are due one clock after the accepting edge. `done` comes one clock after the edge that drains the last result, and for a zero-length run it comes one clock after the start edge. `in_ready` responds to `out_ready` in the same cycle. The bench drives its inputs on the falling edge, advances a behavioural model on each rising edge, and compares every output 3 ns after that edge, so each value is checked in the exact cycle it is due. Stall patterns, a start and a load issued mid-run, and input beats offered while idle show that no result moves early or late.

// File: rtl/madc_pkg.sv
package madc_pkg;

  // Form of the per-element addend
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } mode_e;

  // Default limb geometry
  localparam int LIMB_W_DEF  = 64;
  localparam int DIGIT_W_DEF = 16;
  localparam int LEN_W_DEF   = 8;

endpackage

// File: rtl/madc_mul.sv
// Unsigned W x W multiplier assembled from per-digit partial products of b.
module madc_mul #(
  parameter int W     = 64,
  parameter int DIG_W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);

  localparam int NDIG  = W / DIG_W;
  localparam int PW    = 2 * W;

  initial begin
    assert (W % DIG_W == 0) else $error("limb width must be a multiple of digit width");
  end

  logic [PW-1:0] pp [NDIG];
  logic [PW-1:0] a_ext;

  assign a_ext = {{W{1'b0}}, a};

  for (genvar g = 0; g < NDIG; g++) begin : g_pp
    logic [PW-1:0] d_ext;
    logic [PW-1:0] raw;
    assign d_ext  = {{(PW-DIG_W){1'b0}}, b[g*DIG_W +: DIG_W]};
    assign raw    = a_ext * d_ext;
    assign pp[g]  = raw << (g * DIG_W);
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < NDIG; k++) begin
      prod = prod + pp[k];
    end
  end

endmodule

// File: rtl/madc_datapath.sv
// One element step: product plus selected addend plus carry, split in halves.
module madc_datapath
  import madc_pkg::*;
#(
  parameter int W     = 64,
  parameter int DIG_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] carry_in,
  input  mode_e        mode,
  output logic [W-1:0] sum_lo,
  output logic [W-1:0] sum_hi
);

  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  addend;
  logic [PW:0]   total;

  madc_mul #(.W(W), .DIG_W(DIG_W)) u_mul (
    .a    (a),
    .b    (b),
    .prod (prod)
  );

  assign addend = (mode == MODE_SUB) ? ~c : c;

  assign total = {1'b0, prod}
               + {{(W+1){1'b0}}, addend}
               + {{(W+1){1'b0}}, carry_in};

  assign sum_lo = total[W-1:0];
  assign sum_hi = total[PW-1:W];

  // R11
  sum_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (total[PW] == 1'b0));

endmodule

// File: rtl/madc_ctrl.sv
// Sequencer: launch, element counting, stream gating and end-of-run pulse.
module madc_ctrl
  import madc_pkg::*;
#(
  parameter int W     = 64,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] vlen,
  input  logic             sub_i,
  input  logic [W-1:0]     b_i,
  input  logic             carry_ld,
  input  logic             in_valid,
  input  logic             out_valid,
  input  logic             out_ready,
  input  logic             out_last,
  output logic             in_ready,
  output logic             accept,
  output logic             acc_last,
  output logic [LEN_W-1:0] idx,
  output logic [W-1:0]     b_q,
  output mode_e            mode_q,
  output logic             busy,
  output logic             done,
  output logic             load_en
);

  logic             running;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic             launch;
  logic             drain_last;

  assign busy       = running | out_valid;
  assign launch     = start & ~busy;
  assign load_en    = carry_ld & ~busy;
  assign in_ready   = running & (~out_valid | out_ready);
  assign accept     = in_valid & in_ready;
  assign acc_last   = (cnt == len_q - 1'b1);
  assign idx        = cnt;
  assign drain_last = out_valid & out_ready & out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      b_q     <= '0;
      mode_q  <= MODE_ADD;
    end else if (launch && vlen != '0) begin
      running <= 1'b1;
      cnt     <= '0;
      len_q   <= vlen;
      b_q     <= b_i;
      mode_q  <= sub_i ? MODE_SUB : MODE_ADD;
    end else if (accept) begin
      cnt <= cnt + 1'b1;
      if (acc_last) begin
        running <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= (launch && vlen == '0) || drain_last;
    end
  end

  // R10
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && running) |=> ($stable(len_q) && $stable(b_q) && $stable(mode_q)));

  // R7
  run_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_last) |=> !in_ready);

  // R8
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last |=> done);

endmodule

// File: rtl/madc_outreg.sv
// Single result register on the output stream.
module madc_outreg #(
  parameter int W     = 64,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     res_in,
  input  logic [LEN_W-1:0] idx_in,
  input  logic             last_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_res,
  output logic [LEN_W-1:0] out_idx,
  output logic             out_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_idx   <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_res   <= res_in;
      out_idx   <= idx_in;
      out_last  <= last_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6
  hold_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_idx)));

  // R5
  issue_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_idx == $past(idx_in)));

endmodule

// File: rtl/madc_engine.sv
// Chained multiply-add-carry engine: top level with the carry register.
module madc_engine
  import madc_pkg::*;
#(
  parameter int W     = LIMB_W_DEF,
  parameter int DIG_W = DIGIT_W_DEF,
  parameter int LEN_W = LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] vec_len,
  input  logic             sub_mode,
  input  logic [W-1:0]     scalar_b,
  input  logic             carry_ld,
  input  logic [W-1:0]     carry_ld_val,
  output logic [W-1:0]     carry_q,
  output logic             busy,
  output logic             done,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_c,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_res,
  output logic [LEN_W-1:0] out_idx
);

  logic             accept;
  logic             acc_last;
  logic             load_en;
  logic             out_last;
  logic [LEN_W-1:0] idx;
  logic [W-1:0]     b_q;
  mode_e            mode_q;
  logic [W-1:0]     sum_lo;
  logic [W-1:0]     sum_hi;

  madc_ctrl #(.W(W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vec_len),
    .sub_i     (sub_mode),
    .b_i       (scalar_b),
    .carry_ld  (carry_ld),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .in_ready  (in_ready),
    .accept    (accept),
    .acc_last  (acc_last),
    .idx       (idx),
    .b_q       (b_q),
    .mode_q    (mode_q),
    .busy      (busy),
    .done      (done),
    .load_en   (load_en)
  );

  madc_datapath #(.W(W), .DIG_W(DIG_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (accept),
    .a        (in_a),
    .b        (b_q),
    .c        (in_c),
    .carry_in (carry_q),
    .mode     (mode_q),
    .sum_lo   (sum_lo),
    .sum_hi   (sum_hi)
  );

  madc_outreg #(.W(W), .LEN_W(LEN_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .res_in    (sum_lo),
    .idx_in    (idx),
    .last_in   (acc_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_idx   (out_idx),
    .out_last  (out_last)
  );

  // Carry register: the high half of each step, or a software load while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= '0;
    end else if (accept) begin
      carry_q <= sum_hi;
    end else if (load_en) begin
      carry_q <= carry_ld_val;
    end
  end

  // R4
  load_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && carry_ld && !in_ready) |=> $stable(carry_q));

  // R9
  empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vec_len == '0 && !carry_ld) |=> ($stable(carry_q) && !out_valid && done));

  // R6
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/madc_engine_test.sv
`timescale 1ns/1ps
module madc_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vec_len = '0;
  logic        sub_mode = 1'b0;
  logic [63:0] scalar_b = '0;
  logic        carry_ld = 1'b0;
  logic [63:0] carry_ld_val = '0;
  logic [63:0] carry_q;
  logic        busy, done;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_c = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_res;
  logic [7:0]  out_idx;

  always #2 clk = ~clk;

  madc_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len), .sub_mode(sub_mode),
    .scalar_b(scalar_b), .carry_ld(carry_ld), .carry_ld_val(carry_ld_val), .carry_q(carry_q),
    .busy(busy), .done(done), .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a),
    .in_c(in_c), .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res), .out_idx(out_idx)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Stimulus memory and knobs
  logic [63:0] vec_a [256];
  logic [63:0] vec_c [256];
  logic [63:0] cap   [256];
  int p_vld = 100, p_rdy = 100;
  bit spam = 1'b0;
  bit compare_on = 1'b0;
  int n_out = 0, done_cnt = 0;

  // Behavioural reference model
  bit          m_run = 0, m_sub = 0, m_ov = 0, m_last = 0, m_done = 0;
  int          m_cnt = 0, m_len = 0, m_idx = 0;
  logic [63:0] m_b = '0, m_carry = '0, m_res = '0;
  int          cyc = 0;

  function automatic bit m_busy();
    return m_run || m_ov;
  endfunction

  function automatic bit m_ready();
    return m_run && (!m_ov || out_ready);
  endfunction

  always @(posedge clk) begin
    bit b_old, acc, hs, nd;
    logic [127:0] full;
    logic [63:0]  addv;
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_sub = 0; m_ov = 0; m_last = 0; m_done = 0;
      m_cnt = 0; m_len = 0; m_idx = 0; m_b = '0; m_carry = '0; m_res = '0;
    end else begin
      b_old = m_busy();
      acc   = in_valid && m_ready();
      hs    = m_ov && out_ready;
      nd    = hs && m_last;
      if (acc) begin
        addv    = m_sub ? ~in_c : in_c;
        full    = {64'd0, in_a} * {64'd0, m_b} + {64'd0, addv} + {64'd0, m_carry};
        m_res   = full[63:0];
        m_carry = full[127:64];
        m_idx   = m_cnt;
        m_ov    = 1;
        m_last  = (m_cnt == m_len - 1);
        if (m_last) m_run = 0;
        m_cnt++;
      end else if (hs) begin
        m_ov = 0;
      end
      if (carry_ld && !b_old) m_carry = carry_ld_val;
      if (start && !b_old) begin
        if (vec_len == 0) nd = 1;
        else begin
          m_run = 1; m_cnt = 0; m_len = vec_len; m_b = scalar_b; m_sub = sub_mode;
        end
      end
      m_done = nd;
    end
  end

  // Compare every cycle, late in the cycle after inputs have settled
  always @(posedge clk) begin
    #3;
    if (compare_on) begin
      chk("R5", "out_valid", {63'd0, out_valid}, {63'd0, m_ov});
      chk("R6", "in_ready", {63'd0, in_ready}, {63'd0, m_ready()});
      chk("R10", "busy", {63'd0, busy}, {63'd0, m_busy()});
      chk("R8", "done", {63'd0, done}, {63'd0, m_done});
      chk("R3", "carry_q", carry_q, m_carry);
      if (m_ov) begin
        chk("R1", "out_res", out_res, m_res);
        chk("R5", "out_idx", {56'd0, out_idx}, m_idx[63:0]);
      end
    end
    if (out_valid && out_ready) begin
      cap[out_idx] = out_res;
      n_out++;
    end
    if (done) done_cnt++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Input and output stream drivers
  always @(negedge clk) begin
    in_valid  <= spam || (m_run && ($urandom_range(99) < p_vld));
    in_a      <= vec_a[m_cnt & 255];
    in_c      <= vec_c[m_cnt & 255];
    out_ready <= ($urandom_range(99) < p_rdy);
  end

  task automatic run(input int n, input bit sub, input logic [63:0] b, input logic [63:0] cin);
    int guard;
    @(negedge clk);
    carry_ld = 1; carry_ld_val = cin;
    @(negedge clk);
    carry_ld = 0;
    n_out = 0; done_cnt = 0;
    start = 1; vec_len = n[7:0]; sub_mode = sub; scalar_b = b;
    @(negedge clk);
    start = 0;
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      vec_a[i] = '0; vec_c[i] = '0; cap[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "out_valid", {63'd0, out_valid}, 64'd0);
    chk("R12", "in_ready", {63'd0, in_ready}, 64'd0);
    chk("R12", "busy", {63'd0, busy}, 64'd0);
    chk("R12", "carry_q", carry_q, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "done", {63'd0, done}, 64'd0);
    compare_on = 1;

    // R1: add form with a carry out of element 0
    vec_a[0] = 64'hFFFF_FFFF_FFFF_FFFF; vec_c[0] = 64'd1;
    vec_a[1] = 64'd1;                   vec_c[1] = 64'd0;
    run(2, 0, 64'd2, 64'd0);
    chk("R1", "elem0", cap[0], 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3", "elem1 uses carry", cap[1], 64'd3);
    chk("R3", "final carry", carry_q, 64'd0);
    chk("R8", "done pulses", done_cnt, 1);

    // R2: subtract form, carry preset to 1
    vec_a[0] = 64'd5; vec_c[0] = 64'd7;
    vec_a[1] = 64'd0; vec_c[1] = 64'd0;
    p_rdy = 50; p_vld = 70;
    run(2, 1, 64'd3, 64'd1);
    chk("R2", "elem0", cap[0], 64'd8);
    chk("R2", "elem1", cap[1], 64'd0);
    chk("R2", "final carry", carry_q, 64'd1);

    // R11: all-ones operands
    for (int i = 0; i < 3; i++) begin
      vec_a[i] = '1; vec_c[i] = '1;
    end
    p_rdy = 100; p_vld = 100;
    run(3, 0, '1, '1);
    for (int i = 0; i < 3; i++) chk("R11", "all-ones result", cap[i], '1);
    chk("R11", "all-ones carry", carry_q, '1);

    // R6 R7: long random runs under back-pressure
    for (int i = 0; i < 256; i++) begin
      vec_a[i] = {$urandom, $urandom}; vec_c[i] = {$urandom, $urandom};
    end
    p_rdy = 40; p_vld = 60;
    run(40, 0, {$urandom, $urandom}, {$urandom, $urandom});
    chk("R7", "result count add", n_out, 40);
    p_rdy = 25; p_vld = 90;
    run(20, 1, {$urandom, $urandom}, 64'd1);
    chk("R7", "result count sub", n_out, 20);

    // R9: zero length keeps the carry and still signals done
    p_rdy = 100;
    run(0, 0, 64'd9, 64'h1234);
    chk("R9", "no results", n_out, 0);
    chk("R9", "carry kept", carry_q, 64'h1234);
    chk("R9", "done seen", done_cnt, 1);

    // R10 R4 R3: start, load and scalar change during a run
    p_rdy = 30; p_vld = 80;
    fork
      run(10, 0, 64'd77, 64'd5);
      begin
        repeat (6) @(negedge clk);
        start = 1; vec_len = 8'd3; carry_ld = 1; carry_ld_val = 64'hDEAD; scalar_b = 64'd1;
        @(negedge clk);
        start = 0; carry_ld = 0;
      end
    join
    chk("R10", "length kept", n_out, 10);
    chk("R4", "busy load ignored", carry_q, m_carry);

    // R7: beats offered while idle are ignored
    n_out = 0;
    spam = 1;
    repeat (5) @(negedge clk);
    spam = 0;
    @(negedge clk);
    chk("R7", "idle beats ignored", n_out, 0);

    // R4: idle load takes effect
    @(negedge clk);
    carry_ld = 1; carry_ld_val = 64'hCAFE;
    @(negedge clk);
    carry_ld = 0;
    chk("R4", "idle load", carry_q, 64'hCAFE);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule